// File: doc/BRIEF.md
# Colour Grading LUT Access Port

This block is a byte-wide register window onto a set of colour-grading lookup tables kept in on-chip storage. Software never addresses a table entry directly. It first writes a control byte that picks one of six tables and an access mode. It then writes an index byte that points at one of 64 entries. Finally it moves a 16-bit entry through two value registers, one byte at a time.

Bytes are paired so that an entry always changes as a whole. A low-byte write is held in a side buffer. Memory is updated only when the high byte arrives. A low-byte read captures the complete entry, so the high-byte read that follows returns the other half of that same capture. In bulk mode the index steps forward after every high-byte access, which lets a full table be streamed without rewriting the index. Each table stores only as many bits as it defines, and accesses aimed at a reserved table code or a non-zero page are neutralised.

The access port has four register slots. Read data appears on the clock edge that follows the read access and is held until the next read.

Top module: `cglut_port`

## Requirements
- R1: After synchronous reset the control byte, the index and the read-data output are all 0.
- R2: Slot 0 is the control byte. Bits 7:5 give the table code, bits 4:1 give the page and bit 0 selects bulk mode. Reading slot 0 returns the byte last written.
- R3: Slot 1 is the index. Only bits 5:0 are kept, and reading slot 1 returns those bits with bits 7:6 as zero.
- R4: Slot 2 carries bits 7:0 of an entry and slot 3 carries bits 15:8. A slot-2 write only buffers its byte. The entry at the selected table and index is written only by a slot-3 write, using the buffered byte as its low half.
- R5: A slot-2 read captures the whole selected entry. A later slot-3 read returns the high half of that capture, even if the entry was rewritten in between.
- R6: Table code 0 keeps 14-bit entries and codes 1 to 5 keep 12-bit entries. Higher bits are stored and read back as zero.
- R7: In bulk mode the index increases by one after each slot-3 access, whether read or write. Slot-2 accesses never move it, and with bulk mode off slot-3 accesses leave it unchanged.
- R8: A bulk-mode increment from index 63 gives index 0.
- R9: With table code 6 or 7 selected, slot-3 writes change no table, and a slot-2/slot-3 read pair returns 0x0000.
- R10: With a non-zero page selected, slot-3 writes change no table, and reads return 0x0000.
- R11: Each of the six tables keeps its own contents, so equal indices in different tables hold independent values.
- R12: A bulk-mode slot-3 write commits at the index in force before that same access advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_we | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 2 | Slot: 0 control, 1 index, 2 value low, 3 value high |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid from the edge after a read access |

## Verification
Two actions share one edge: a bulk-mode high-byte write commits its entry, and the index advances. The bench provokes this by streaming consecutive entries in bulk mode. It then rewinds the index and reads every entry back, which shows that each value landed in the slot named before its own increment and not the slot after it. The same overlap is tested at the end of the table, where a commit at index 63 must coincide with the index wrapping to 0.

// File: rtl/cglut_pkg.sv
package cglut_pkg;

    localparam int BYTE_W    = 8;
    localparam int ENTRY_W   = 16;
    localparam int CODE_W    = 3;
    localparam int PAGE_W    = 4;
    localparam int WIDE_BITS = 14;
    localparam int NARROW_BITS = 12;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_INDEX  = 2'd1,
        SLOT_VAL_LO = 2'd2,
        SLOT_VAL_HI = 2'd3
    } slot_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PAGE_W-1:0] page;
        logic              bulk;
    } ctrl_t;

    function automatic logic [ENTRY_W-1:0] entry_mask(input logic [CODE_W-1:0] code);
        logic [ENTRY_W-1:0] m;
        if (code == '0) m = ENTRY_W'((32'd1 << WIDE_BITS) - 32'd1);
        else            m = ENTRY_W'((32'd1 << NARROW_BITS) - 32'd1);
        return m;
    endfunction

endpackage

// File: rtl/cglut_ctrl_regs.sv
module cglut_ctrl_regs
    import cglut_pkg::*;
#(
    parameter int NUM_TABLES = 6,
    parameter int IDX_W      = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_en,
    input  logic                acc_we,
    input  slot_e               acc_slot,
    input  logic [BYTE_W-1:0]   ctrl_wdata,
    input  logic [IDX_W-1:0]    idx_wdata,
    output ctrl_t               ctrl_q,
    output logic [IDX_W-1:0]    idx_q,
    output logic                table_ok
);

    localparam logic [IDX_W-1:0] IDX_LAST = '1;

    logic hi_access;
    assign hi_access = acc_en && (acc_slot == SLOT_VAL_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            idx_q  <= '0;
        end else if (acc_en && acc_we && acc_slot == SLOT_CTRL) begin
            ctrl_q <= ctrl_t'(ctrl_wdata);
        end else if (acc_en && acc_we && acc_slot == SLOT_INDEX) begin
            idx_q <= idx_wdata;
        end else if (hi_access && ctrl_q.bulk) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign table_ok = (32'(ctrl_q.code) < NUM_TABLES) && (ctrl_q.page == '0);

    // bulk stepping wraps at the last entry
    assert_idx_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (hi_access && ctrl_q.bulk && idx_q == IDX_LAST) |=> (idx_q == '0));

    assert_idx_step_R7: assert property (@(posedge clk) disable iff (rst)
        (hi_access && ctrl_q.bulk) |=> (idx_q == $past(idx_q) + 1'b1));

    assert_idx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (hi_access && !ctrl_q.bulk) |=> $stable(idx_q));

endmodule

// File: rtl/cglut_table_mem.sv
module cglut_table_mem
    import cglut_pkg::*;
#(
    parameter int NUM_TABLES = 6,
    parameter int IDX_W      = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CODE_W-1:0]   sel,
    input  logic [IDX_W-1:0]    idx,
    input  logic [ENTRY_W-1:0]  wr_data,
    output logic [ENTRY_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] bank_rd [NUM_TABLES];

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_bank
        logic [ENTRY_W-1:0] store [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && sel == CODE_W'(t)) store[idx] <= wr_data;
        end
        assign bank_rd[t] = store[idx];
    end

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < NUM_TABLES; t++) begin
            if (sel == CODE_W'(t)) rd_data = bank_rd[t];
        end
    end

    // bits above the table's width never reach storage
    assert_store_width_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_data & ~entry_mask(sel)) == '0));

    assert_no_reserved_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(sel) < NUM_TABLES));

endmodule

// File: rtl/cglut_value_pair.sv
module cglut_value_pair
    import cglut_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_en,
    input  logic                acc_we,
    input  slot_e               acc_slot,
    input  logic [BYTE_W-1:0]   acc_wdata,
    input  ctrl_t               ctrl_q,
    input  logic [IDX_W-1:0]    idx_q,
    input  logic                table_ok,
    input  logic [ENTRY_W-1:0]  mem_rdata,
    output logic                mem_wr_en,
    output logic [ENTRY_W-1:0]  mem_wdata,
    output logic [BYTE_W-1:0]   acc_rdata
);

    logic [BYTE_W-1:0]  lo_buf;
    logic [ENTRY_W-1:0] hold_q;
    logic [ENTRY_W-1:0] mask;
    logic [ENTRY_W-1:0] fetched;

    assign mask      = entry_mask(ctrl_q.code);
    assign fetched   = table_ok ? (mem_rdata & mask) : '0;
    assign mem_wr_en = acc_en && acc_we && acc_slot == SLOT_VAL_HI && table_ok;
    assign mem_wdata = {acc_wdata, lo_buf} & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_buf    <= '0;
            hold_q    <= '0;
            acc_rdata <= '0;
        end else if (acc_en && acc_we) begin
            if (acc_slot == SLOT_VAL_LO) lo_buf <= acc_wdata;
        end else if (acc_en) begin
            unique case (acc_slot)
                SLOT_CTRL:   acc_rdata <= BYTE_W'(ctrl_q);
                SLOT_INDEX:  acc_rdata <= BYTE_W'(idx_q);
                SLOT_VAL_LO: begin
                    hold_q    <= fetched;
                    acc_rdata <= fetched[BYTE_W-1:0];
                end
                SLOT_VAL_HI: acc_rdata <= hold_q[ENTRY_W-1:BYTE_W];
            endcase
        end
    end

    assert_hi_from_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_we && acc_slot == SLOT_VAL_HI) |=> (acc_rdata == $past(hold_q[ENTRY_W-1:BYTE_W])));

    assert_reserved_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_we && acc_slot == SLOT_VAL_LO && !table_ok) |=> (acc_rdata == '0 && hold_q == '0));

    assert_lo_write_no_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_slot == SLOT_VAL_LO) |-> !mem_wr_en);

endmodule

// File: rtl/cglut_port.sv
module cglut_port
    import cglut_pkg::*;
#(
    parameter int NUM_TABLES = 6,
    parameter int IDX_W      = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_en,
    input  logic        acc_we,
    input  logic [1:0]  acc_addr,
    input  logic [7:0]  acc_wdata,
    output logic [7:0]  acc_rdata
);

    slot_e              slot;
    ctrl_t              ctrl_q;
    logic [IDX_W-1:0]   idx_q;
    logic               table_ok;
    logic               mem_wr_en;
    logic [ENTRY_W-1:0] mem_wdata;
    logic [ENTRY_W-1:0] mem_rdata;

    assign slot = slot_e'(acc_addr);

    cglut_ctrl_regs #(.NUM_TABLES(NUM_TABLES), .IDX_W(IDX_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .acc_en     (acc_en),
        .acc_we     (acc_we),
        .acc_slot   (slot),
        .ctrl_wdata (acc_wdata),
        .idx_wdata  (acc_wdata[IDX_W-1:0]),
        .ctrl_q     (ctrl_q),
        .idx_q      (idx_q),
        .table_ok   (table_ok)
    );

    cglut_table_mem #(.NUM_TABLES(NUM_TABLES), .IDX_W(IDX_W)) mem_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mem_wr_en),
        .sel     (ctrl_q.code),
        .idx     (idx_q),
        .wr_data (mem_wdata),
        .rd_data (mem_rdata)
    );

    cglut_value_pair #(.IDX_W(IDX_W)) pair_i (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_slot  (slot),
        .acc_wdata (acc_wdata),
        .ctrl_q    (ctrl_q),
        .idx_q     (idx_q),
        .table_ok  (table_ok),
        .mem_rdata (mem_rdata),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .acc_rdata (acc_rdata)
    );

endmodule

// File: tb/cglut_port_tb_top.sv
`timescale 1ns/1ps
module cglut_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_en;
    logic       acc_we;
    logic [1:0] acc_addr;
    logic [7:0] acc_wdata;
    logic [7:0] acc_rdata;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    cglut_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        @(negedge clk);
        acc_en = 1'b0;
        d = acc_rdata;
    endtask

    task automatic put_pair(input logic [15:0] v);
        wr(2'd2, v[7:0]);
        wr(2'd3, v[15:8]);
    endtask

    task automatic get_pair(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd2, lo);
        rd(2'd3, hi);
        v = {hi, lo};
    endtask

    task automatic put_entry(input logic [2:0] code, input logic [5:0] idx, input logic [15:0] v);
        wr(2'd0, {code, 4'd0, 1'b0});
        wr(2'd1, {2'b00, idx});
        put_pair(v);
    endtask

    task automatic get_entry(input logic [2:0] code, input logic [5:0] idx, output logic [15:0] v);
        wr(2'd0, {code, 4'd0, 1'b0});
        wr(2'd1, {2'b00, idx});
        get_pair(v);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 rdata after reset", {8'h0, acc_rdata}, 16'h0000);
        rd(2'd0, d); check("R1 control after reset", {8'h0, d}, 16'h0000);
        rd(2'd1, d); check("R1 index after reset", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr(2'd0, 8'hA7);
        rd(2'd0, d); check("R2 control readback", {8'h0, d}, 16'h00A7);
        wr(2'd1, 8'hC5);
        rd(2'd1, d); check("R3 index upper bits dropped", {8'h0, d}, 16'h0005);
    endtask

    task automatic t_pairing;
        logic [15:0] v;
        put_entry(3'd1, 6'd10, 16'h0ABC);
        get_entry(3'd1, 6'd10, v); check("R4 entry round trip", v, 16'h0ABC);
        put_entry(3'd1, 6'd11, 16'h0123);
        wr(2'd2, 8'h77);
        get_entry(3'd1, 6'd11, v); check("R4 low write alone not committed", v, 16'h0123);
    endtask

    task automatic t_width;
        logic [15:0] v;
        put_entry(3'd0, 6'd2, 16'hFFFF);
        put_entry(3'd5, 6'd2, 16'hFFFF);
        put_entry(3'd3, 6'd2, 16'h5A5A);
        get_entry(3'd0, 6'd2, v); check("R6 table 0 keeps 14 bits", v, 16'h3FFF);
        get_entry(3'd5, 6'd2, v); check("R6 table 5 keeps 12 bits", v, 16'h0FFF);
        get_entry(3'd3, 6'd2, v); check("R6 table 3 keeps 12 bits", v, 16'h0A5A);
        put_entry(3'd2, 6'd2, 16'h0321);
        get_entry(3'd0, 6'd2, v); check("R11 table 0 unaffected by others", v, 16'h3FFF);
        get_entry(3'd2, 6'd2, v); check("R11 table 2 own value", v, 16'h0321);
    endtask

    task automatic t_capture;
        logic [7:0] lo, hi;
        logic [15:0] v;
        put_entry(3'd2, 6'd4, 16'h0111);
        rd(2'd2, lo);
        check("R5 low byte of capture", {8'h0, lo}, 16'h0011);
        put_pair(16'h0222);
        rd(2'd3, hi);
        check("R5 high byte from earlier capture", {8'h0, hi}, 16'h0001);
        get_pair(v); check("R5 fresh capture sees new entry", v, 16'h0222);
    endtask

    task automatic t_bulk;
        logic [7:0] d;
        logic [15:0] v;
        wr(2'd0, {3'd3, 4'd0, 1'b1});
        wr(2'd1, 8'd20);
        for (int k = 1; k <= 3; k++) put_pair(16'(k * 16'h0101));
        rd(2'd1, d); check("R7 index after three bulk writes", {8'h0, d}, 16'd23);
        wr(2'd1, 8'd20);
        for (int k = 1; k <= 3; k++) begin
            get_pair(v);
            check("R12 bulk commit at pre-step index", v, 16'(k * 16'h0101));
        end
        rd(2'd1, d); check("R7 index after three bulk reads", {8'h0, d}, 16'd23);
        rd(2'd2, d);
        rd(2'd1, d); check("R7 low access does not step", {8'h0, d}, 16'd23);
        wr(2'd0, {3'd3, 4'd0, 1'b0});
        get_pair(v);
        put_pair(16'h0044);
        rd(2'd1, d); check("R7 no step without bulk", {8'h0, d}, 16'd23);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        logic [15:0] v;
        wr(2'd0, {3'd4, 4'd0, 1'b1});
        wr(2'd1, 8'd63);
        put_pair(16'h0AAA);
        rd(2'd1, d); check("R8 index wraps to 0", {8'h0, d}, 16'd0);
        put_pair(16'h0BBB);
        get_entry(3'd4, 6'd63, v); check("R8 entry 63 written before wrap", v, 16'h0AAA);
        get_entry(3'd4, 6'd0, v); check("R8 entry 0 written after wrap", v, 16'h0BBB);
    endtask

    task automatic t_reserved;
        logic [15:0] v;
        put_entry(3'd1, 6'd7, 16'h0555);
        wr(2'd0, {3'd6, 4'd0, 1'b0});
        wr(2'd1, 8'd7);
        put_pair(16'h0FFF);
        get_pair(v); check("R9 code 6 reads zero", v, 16'h0000);
        wr(2'd0, {3'd7, 4'd0, 1'b0});
        get_pair(v); check("R9 code 7 reads zero", v, 16'h0000);
        get_entry(3'd1, 6'd7, v); check("R9 real table untouched", v, 16'h0555);
    endtask

    task automatic t_page;
        logic [15:0] v;
        put_entry(3'd1, 6'd8, 16'h0444);
        wr(2'd0, {3'd1, 4'd1, 1'b0});
        wr(2'd1, 8'd8);
        put_pair(16'h0999);
        get_pair(v); check("R10 non-zero page reads zero", v, 16'h0000);
        get_entry(3'd1, 6'd8, v); check("R10 non-zero page write ignored", v, 16'h0444);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_en = 1'b0; acc_we = 1'b0; acc_addr = 2'd0; acc_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_pairing;
        t_width;
        t_capture;
        t_bulk;
        t_wrap;
        t_reserved;
        t_page;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule